// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART and an infrared transceiver. On the transmit side it turns each zero bit of the NRZ stream into one short high pulse. The pulse lasts three ticks of the UART's 16x oversampling enable. A one bit sends nothing. On the receive side it turns each incoming light pulse back into a low bit that lasts one full bit period. Because all timing counts ticks of the 16x enable, the pulse widths follow whatever baud rate the UART is set to.

Infrared mode has an enable flag. At reset the flag takes the level of a strap input. Software can then set or clear it with a one-cycle write strobe. While the flag is clear, both directions pass straight through in plain NRZ form. The receive path always goes through a short synchronizer.

The serializer supplies two inputs alongside its NRZ data. One is the 16x tick. The other is a bit-start strobe that marks the first tick of each bit cell.

Top module: `irsir_codec`

## Requirements
- R1: While `rstN` is low, the infrared enable flag loads the level of `strapIrEn`. Once reset ends, no pulse is in progress: `irTx` is 0 and `rxNrz` is 1 when the flag is set.
- R2: With infrared on, a clock edge on which `tick16`, `txBitStart` and `txNrz==0` all hold starts a pulse. `irTx` is 1 from that edge until the third following `tick16` edge, which makes the pulse exactly 3 tick periods long.
- R3: With infrared on, a bit cell that starts with `txNrz==1` produces no pulse, and `irTx` stays 0 (the idle level).
- R4: With infrared on, `rxIn` passes through a two-stage synchronizer. A rising edge at the synchronizer output makes `rxNrz` go low on the next clock edge. The low level lasts until 16 further `tick16` edges have passed. An edge that coincides with a tick reloads the count and does not decrement it.
- R5: A new rising edge on `rxIn` while `rxNrz` is still low restarts the full 16-tick low period.
- R6: With infrared off, `irTx` equals `txNrz` combinationally. `rxNrz` equals `rxIn` delayed by two clock edges. No pulses start.
- R7: A clock edge with `cfgWr` high loads `cfgIrEn` into the enable flag, overriding the strap value. The new mode applies from that edge on.
- R8: Feeding `irTx` back into `rxIn` gives a decoded stream on `rxNrz` that is low exactly for the zero bits. Each low period is one bit period long, plus the fixed synchronizer latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | 16x oversampling enable, one cycle wide |
| txBitStart | input | 1 | Marks the first tick of a transmit bit cell |
| txNrz | input | 1 | NRZ transmit data from the serializer |
| irTx | output | 1 | To the transceiver: pulse-coded data, or NRZ data when infrared is off |
| rxIn | input | 1 | From the transceiver: pulse-coded or NRZ receive data |
| rxNrz | output | 1 | Decoded NRZ data to the deserializer |
| strapIrEn | input | 1 | Enable value loaded during reset |
| cfgWr | input | 1 | Write strobe for the enable flag |
| cfgIrEn | input | 1 | Value written to the enable flag |

## Verification
The bench builds the block with its default parameters: 16 ticks per bit, 3-tick pulses and 2 synchronizer stages. It produces a tick every third clock, so a pulse spans 9 clocks and a decoded bit spans 48. Random receive gaps run from a few clocks to beyond one decoded bit period. This exercises both a retrigger inside the low period and a clean return to high. It also brings a rising edge landing on a tick edge within reach. Loopback with random bytes covers a zero bit that follows a zero bit. Reset with each strap level, followed by software writes, covers both enable paths.

// File: rtl/irsir_pkg.sv
package irsir_pkg;
  typedef struct packed {
    logic irOn;    // infrared mode active
    logic txLoad;  // start a transmit pulse
    logic txStep;  // advance the transmit pulse count
    logic rxLoad;  // synchronized receive rising edge
    logic rxStep;  // advance the receive hold count
  } strb_t;
endpackage

// File: rtl/irsir_ctrl.sv
module irsir_ctrl
  import irsir_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic  clk,
  input  logic  rstN,
  input  logic  tick16,
  input  logic  txBitStart,
  input  logic  txNrz,
  input  logic  rxIn,
  input  logic  strapIrEn,
  input  logic  cfgWr,
  input  logic  cfgIrEn,
  output strb_t strb,
  output logic  rxSynced
);
  logic                   irEn;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxPrev;

  // enable flag: strap during reset, software afterwards
  always_ff @(posedge clk) begin
    if (!rstN)      irEn <= strapIrEn;
    else if (cfgWr) irEn <= cfgIrEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= '0;
      rxPrev <= 1'b0;
    end else begin
      syncQ  <= {syncQ[SYNC_STAGES-2:0], rxIn};
      rxPrev <= syncQ[SYNC_STAGES-1];
    end
  end

  assign rxSynced = syncQ[SYNC_STAGES-1];

  always_comb begin
    strb.irOn   = irEn;
    strb.txLoad = irEn & tick16 & txBitStart & ~txNrz;
    strb.txStep = tick16;
    strb.rxLoad = irEn & rxSynced & ~rxPrev;
    strb.rxStep = tick16;
  end

  AST_EDGE_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxLoad |=> !strb.rxLoad); // R4
  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    cfgWr |=> (strb.irOn == $past(cfgIrEn))); // R7
endmodule

// File: rtl/irsir_datapath.sv
module irsir_datapath
  import irsir_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_TICKS = 3
) (
  input  logic  clk,
  input  logic  rstN,
  input  strb_t strb,
  input  logic  txNrz,
  input  logic  rxSynced,
  output logic  irTx,
  output logic  rxNrz
);
  localparam int CW = $clog2(OVERSAMPLE + 1);
  localparam logic [CW-1:0] TX_LOAD = CW'(PULSE_TICKS);
  localparam logic [CW-1:0] RX_LOAD = CW'(OVERSAMPLE);

  logic [CW-1:0] txLeft;
  logic [CW-1:0] rxLeft;

  always_ff @(posedge clk) begin
    if (!rstN)                          txLeft <= '0;
    else if (strb.txLoad)               txLeft <= TX_LOAD;
    else if (strb.txStep && txLeft != 0) txLeft <= txLeft - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                          rxLeft <= '0;
    else if (strb.rxLoad)               rxLeft <= RX_LOAD;
    else if (strb.rxStep && rxLeft != 0) rxLeft <= rxLeft - 1'b1;
  end

  assign irTx  = strb.irOn ? (txLeft != 0) : txNrz;
  assign rxNrz = strb.irOn ? (rxLeft == 0) : rxSynced;

  AST_TX_PULSE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> (txLeft == TX_LOAD)); // R2
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    txLeft <= TX_LOAD); // R2
  AST_TX_DECAY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.txStep && !strb.txLoad && txLeft != 0) |=> (txLeft == $past(txLeft) - 1'b1)); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.txStep && !strb.txLoad) |=> $stable(txLeft)); // R3
  AST_RX_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    strb.rxLoad |=> (rxLeft == RX_LOAD)); // R5
  AST_RX_DECAY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rxStep && !strb.rxLoad && rxLeft != 0) |=> (rxLeft == $past(rxLeft) - 1'b1)); // R4
endmodule

// File: rtl/irsir_codec.sv
module irsir_codec
  import irsir_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_TICKS = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick16,
  input  logic txBitStart,
  input  logic txNrz,
  output logic irTx,
  input  logic rxIn,
  output logic rxNrz,
  input  logic strapIrEn,
  input  logic cfgWr,
  input  logic cfgIrEn
);
  strb_t strb;
  logic  rxSynced;

  irsir_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick16(tick16), .txBitStart(txBitStart),
    .txNrz(txNrz), .rxIn(rxIn), .strapIrEn(strapIrEn), .cfgWr(cfgWr),
    .cfgIrEn(cfgIrEn), .strb(strb), .rxSynced(rxSynced)
  );

  irsir_datapath #(.OVERSAMPLE(OVERSAMPLE), .PULSE_TICKS(PULSE_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .txNrz(txNrz), .rxSynced(rxSynced),
    .irTx(irTx), .rxNrz(rxNrz)
  );
endmodule

// File: tb/irsir_codec_bench.sv
module irsir_codec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;
  localparam int BIT_TICKS  = 16;
  localparam int PULSE      = 3;

  logic clk = 1'b0;
  logic rstN, tick16, txBitStart, txNrz, irTx, rxIn, rxNrz;
  logic strapIrEn, cfgWr, cfgIrEn;

  irsir_codec u_irsir_codec (
    .clk(clk), .rstN(rstN), .tick16(tick16), .txBitStart(txBitStart),
    .txNrz(txNrz), .irTx(irTx), .rxIn(rxIn), .rxNrz(rxNrz),
    .strapIrEn(strapIrEn), .cfgWr(cfgWr), .cfgIrEn(cfgIrEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int testsRun = 0;
  int testsFailed = 0;
  int cyc = 0;
  int tickNo = 0;
  string rxTag = "R4";
  bit loopback = 1'b0;
  bit passMode = 1'b0;

  // bench model state
  bit enM = 1'b0;
  bit d0 = 1'b0, d1 = 1'b0, prevM = 1'b0;
  int hold = 0;
  int phase = 100;
  bit armed = 1'b0;
  bit [7:0] curByte = 8'h00;
  int bitIdx = 0;

  function automatic bit expTx();
    if (enM) return armed && (phase < PULSE);
    return txNrz;
  endfunction

  function automatic bit expRx();
    if (enM) return hold == 0;
    return d1;
  endfunction

  task automatic check(string tag, bit act, bit exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s cycle %0d actual %0b expected %0b", tag, cyc, act, exp);
    end
  endtask

  task automatic modelEdge();
    bit rise;
    if (!rstN) begin
      enM = strapIrEn; d0 = 0; d1 = 0; prevM = 0; hold = 0; phase = 100; armed = 0;
      return;
    end
    rise = enM && d1 && !prevM;
    prevM = d1; d1 = d0; d0 = rxIn;
    if (rise) hold = BIT_TICKS;
    else if (tick16 && hold > 0) hold--;
    if (tick16) begin
      if (txBitStart) begin
        phase = 0;
        armed = enM && !txNrz;
      end else if (phase < 100) phase++;
    end
    if (cfgWr) enM = cfgIrEn;
  endtask

  // one clock: inputs already driven; model at edge; check at negedge
  task automatic step(bit doCheck);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    if (doCheck) begin
      if (passMode) check("R6 tx", irTx, expTx());
      else check(armed ? "R2 tx" : "R3 tx", irTx, expTx());
      check(passMode ? "R6 rx" : rxTag, rxNrz, expRx());
    end
    cyc++;
    tick16 = (cyc % TICK_DIV == 0);
    txBitStart = 1'b0;
    if (tick16) begin
      tickNo++;
      txBitStart = (tickNo % BIT_TICKS == 0);
    end
    cfgWr = 1'b0;
    if (txBitStart && !passMode) begin
      txNrz = curByte[bitIdx];
      bitIdx = (bitIdx + 1) % 8;
      if (bitIdx == 0) curByte = 8'($urandom);
    end
    if (loopback) rxIn = irTx;
  endtask

  task automatic doReset(bit strap);
    rstN = 1'b0; strapIrEn = strap;
    repeat (4) step(1'b0);
    rstN = 1'b1;
    step(1'b0);
    check("R1 strap", irTx, strap ? 1'b0 : txNrz);
    check("R1 rx", rxNrz, strap ? 1'b1 : 1'b0);
  endtask

  initial begin
    void'($urandom(32'd4747));
    rstN = 0; tick16 = 0; txBitStart = 0; txNrz = 1; rxIn = 0;
    strapIrEn = 1; cfgWr = 0; cfgIrEn = 0;
    @(negedge clk);

    // strap on, loopback with random bytes (R2, R3, R8)
    curByte = 8'h00;
    doReset(1'b1);
    rxTag = "R8";
    loopback = 1'b1;
    repeat (40 * BIT_TICKS * TICK_DIV) step(1'b1);
    loopback = 1'b0;
    rxIn = 1'b0;

    // random receive pulses with retriggers (R4, R5), tx idle ones
    curByte = 8'hFF;
    rxTag = "R5";
    for (int p = 0; p < 120; p++) begin
      int w = 1 + int'($urandom % 6);
      int g = 2 + int'($urandom % 70);
      rxIn = 1'b1;
      for (int k = 0; k < w; k++) begin step(1'b1); if (!loopback) rxIn = 1'b1; end
      rxIn = 1'b0;
      for (int k = 0; k < g; k++) step(1'b1);
    end
    repeat (60) step(1'b1);
    rxTag = "R4";
    // directed: single pulse then full quiet period
    rxIn = 1'b1; step(1'b1); step(1'b1); rxIn = 1'b0;
    repeat (70) step(1'b1);

    // software disables infrared (R7), then passthrough (R6)
    cfgWr = 1'b1; cfgIrEn = 1'b0;
    step(1'b1);
    check("R7 write off", irTx, txNrz);
    passMode = 1'b1;
    for (int k = 0; k < 600; k++) begin
      txNrz = 1'($urandom);
      rxIn = 1'($urandom);
      step(1'b1);
    end

    // strap off reset, then software enables (R1, R7)
    passMode = 1'b0;
    txNrz = 1'b1; rxIn = 1'b0;
    doReset(1'b0);
    passMode = 1'b1;
    repeat (20) step(1'b1);
    passMode = 1'b0;
    txNrz = 1'b1;
    cfgWr = 1'b1; cfgIrEn = 1'b1;
    step(1'b1);
    check("R7 write on", rxNrz, 1'b1);
    curByte = 8'h5A;
    rxTag = "R8";
    loopback = 1'b1;
    repeat (20 * BIT_TICKS * TICK_DIV) step(1'b1);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule